// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block predicts whether a hard conditional branch will be taken. It serves the branches that a simple predictor gets wrong. It keeps a direct-mapped table of branch records, selected by the low bits of the branch address and tagged with the upper bits. Each record holds a 4-bit history of that branch's own recent outcomes. That history selects one of sixteen 2-bit saturating counters. The counters are shared by all branches, and the chosen counter gives the direction.

A lookup request carries an address and a static-hint flag. The direction and a hit flag come back on the next cycle. A resolve carries the address, the real outcome and the same hint. On a hit, the resolve trains the counter that the old history selected, then shifts the outcome into that history. On a miss, an unhinted resolve claims the record. A branch marked by the compiler as easy to predict never takes a record and never changes any state.

Top module: `lhp_predictor`

## Requirements
- R1: After reset no record is valid and every counter holds 1. Any lookup after reset returns hit=0 and taken=0.
- R2: `pred_valid_o` is high exactly one cycle after `pred_valid_i` was high. The lookup results are registered, so they are valid in that same cycle.
- R3: A lookup whose record is invalid or whose tag differs returns hit=0 and taken=0. The index is `addr[5:0]` and the tag is `addr[31:6]`.
- R4: An unhinted resolve that misses writes the tag, sets the record valid and clears its history to 0. It changes no counter.
- R5: A hinted resolve changes no state. A hinted lookup returns hit=0 and taken=0, even for an address that has a record.
- R6: A resolve that hits shifts the outcome into the record's history at bit 0 (1 = taken), drops bit 3, and keeps 4 bits.
- R7: A resolve that hits trains the counter indexed by the record's history from before the shift. A taken outcome adds 1 and saturates at 3; a not-taken outcome subtracts 1 and saturates at 0. A hit lookup predicts taken when the selected counter is 2 or more.
- R8: The counters are shared. Two branches whose histories are equal read and train the same counter.
- R9: A resolve to an address that shares the index of a valid record but has a different tag replaces that record.
- R10: When a lookup and a resolve reach the same record in one cycle, the lookup sees the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid_i | input | 1 | Lookup request |
| pred_addr_i | input | 32 | Lookup branch address |
| pred_hint_i | input | 1 | Lookup branch is statically easy |
| res_valid_i | input | 1 | Resolve update |
| res_addr_i | input | 32 | Resolved branch address |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_hint_i | input | 1 | Resolved branch is statically easy |
| pred_valid_o | output | 1 | Lookup result valid |
| pred_hit_o | output | 1 | A record matched the lookup |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
Directed sequences cover the following cases:
- A cold lookup.
- Allocation of a record, then a lookup of it.
- A long taken run that drives the all-ones history and its counter to saturation.
- A second branch that reads a counter trained by the first.
- An alias with the same index but a different tag, which tells index decode apart from tag compare.
- A lookup and a resolve to the same record in one cycle, which tells old state from new state.
- Hinted traffic on both ports.

Constrained random traffic then draws addresses from a small pool that contains aliases. This mixes hits, misses, evictions and both outcome directions. A reference model in the bench predicts every result.

// File: rtl/lhp_pkg.sv
// Package: shared types for the per-branch history predictor.
// Assumes: 2-bit counters; all sizing parameters live on the top module.
package lhp_pkg;
    typedef logic [1:0] ctr_t;
    localparam ctr_t CTR_RESET = 2'd1;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_MIN   = 2'd0;
endpackage

// File: rtl/lhp_hist_table.sv
// History table: a direct-mapped array of {valid, tag, history} records.
// It has one combinational read port for lookups and one for resolves.
// On a resolve it writes once: allocate on a miss, shift the history on a hit.
// Assumes: the caller already removed hinted resolves from wr_en.
module lhp_hist_table #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 26,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_taken,
    output logic              wr_hit,
    output logic [HIST_W-1:0] wr_hist
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [HIST_W-1:0]  hist_q [ENTRIES];

    // Lookup port: match the tag against the indexed record.
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_hist = hist_q[lk_idx];
    end

    // Resolve port: match the tag and return the history from before the write.
    always_comb begin
        wr_hit  = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
        wr_hist = hist_q[wr_idx];
    end

    // Record update: on a miss, allocate with a cleared history; on a hit, shift the outcome in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                hist_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_hit) begin
                hist_q[wr_idx] <= {wr_hist[HIST_W-2:0], wr_taken};
            end else begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
                hist_q[wr_idx]  <= '0;
            end
        end
    end

    // After an allocation, the record must hold the new tag and a zero history.
    p_alloc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> (valid_q[$past(wr_idx)]
                                && hist_q[$past(wr_idx)] == '0
                                && tag_q[$past(wr_idx)] == $past(wr_tag)));

    // After a hit, the new history must be the old one shifted with the outcome at bit 0.
    p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=> (hist_q[$past(wr_idx)]
                               == {$past(wr_hist[HIST_W-2:0]), $past(wr_taken)}));

    // With no write, the valid bits must not change.
    p_no_write_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/lhp_pattern_table.sv
// Pattern table: shared 2-bit saturating counters, indexed by a history value.
// It has one combinational read port for lookups and one trained update port.
// Assumes: at most one update per cycle.
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              up_en,
    input  logic [HIST_W-1:0] up_idx,
    input  logic              up_taken
);
    localparam int ENTRIES = 1 << HIST_W;

    ctr_t cnt_q [ENTRIES];
    ctr_t up_cur;

    // Direction: the upper counter bit means the count is 2 or more.
    always_comb begin
        rd_taken = cnt_q[rd_idx][1];
        up_cur   = cnt_q[up_idx];
    end

    // Training: step the selected counter toward the outcome, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CTR_RESET;
        end else if (up_en) begin
            if (up_taken && up_cur != CTR_MAX)       cnt_q[up_idx] <= up_cur + 2'd1;
            else if (!up_taken && up_cur != CTR_MIN) cnt_q[up_idx] <= up_cur - 2'd1;
        end
    end

    // A counter already at the top must stay at the top on a taken outcome.
    p_sat_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_taken && up_cur == CTR_MAX) |=> cnt_q[$past(up_idx)] == CTR_MAX);

    // A counter already at the bottom must stay at the bottom on a not-taken outcome.
    p_sat_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_taken && up_cur == CTR_MIN) |=> cnt_q[$past(up_idx)] == CTR_MIN);
endmodule

// File: rtl/lhp_predictor.sv
// Top: per-branch history direction predictor.
// A lookup reads the history table and then the shared counters; the result is registered.
// A resolve trains the counter selected by the old history and updates the record.
// Assumes: hinted branches are handled by another predictor and need no state here.
module lhp_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid_i,
    input  logic [ADDR_W-1:0] pred_addr_i,
    input  logic              pred_hint_i,
    input  logic              res_valid_i,
    input  logic [ADDR_W-1:0] res_addr_i,
    input  logic              res_taken_i,
    input  logic              res_hint_i,
    output logic              pred_valid_o,
    output logic              pred_hit_o,
    output logic              pred_taken_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              lk_hit, wr_hit, res_en, pt_taken;
    logic [HIST_W-1:0] lk_hist, wr_hist;

    // Hinted resolves never reach the storage.
    always_comb res_en = res_valid_i && !res_hint_i;

    lhp_hist_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (pred_addr_i[IDX_W-1:0]),
        .lk_tag   (pred_addr_i[ADDR_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_hist  (lk_hist),
        .wr_en    (res_en),
        .wr_idx   (res_addr_i[IDX_W-1:0]),
        .wr_tag   (res_addr_i[ADDR_W-1:IDX_W]),
        .wr_taken (res_taken_i),
        .wr_hit   (wr_hit),
        .wr_hist  (wr_hist)
    );

    lhp_pattern_table #(.HIST_W(HIST_W)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_hist),
        .rd_taken (pt_taken),
        .up_en    (res_en && wr_hit),
        .up_idx   (wr_hist),
        .up_taken (res_taken_i)
    );

    // Result register: captures the state from before any resolve at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid_o <= 1'b0;
            pred_hit_o   <= 1'b0;
            pred_taken_o <= 1'b0;
        end else begin
            pred_valid_o <= pred_valid_i;
            pred_hit_o   <= pred_valid_i && !pred_hint_i && lk_hit;
            pred_taken_o <= pred_valid_i && !pred_hint_i && lk_hit && pt_taken;
        end
    end

    // A request must produce a valid result on the next cycle.
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> pred_valid_o);

    // No request must produce no result on the next cycle.
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_i |=> !pred_valid_o);

    // A miss must never predict taken.
    p_miss_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_o && !pred_hit_o) |-> !pred_taken_o);

    // A hinted lookup must not report a hit.
    p_hint_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && pred_hint_i) |=> !pred_hit_o);
endmodule

// File: tb/lhp_predictor_test.sv
`timescale 1ns/1ps
module lhp_predictor_test;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int NREC   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_valid_i = 1'b0, pred_hint_i = 1'b0;
    logic res_valid_i = 1'b0, res_taken_i = 1'b0, res_hint_i = 1'b0;
    logic [ADDR_W-1:0] pred_addr_i = '0, res_addr_i = '0;
    logic pred_valid_o, pred_hit_o, pred_taken_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state.
    bit                    m_val  [NREC];
    bit [ADDR_W-IDX_W-1:0] m_tag  [NREC];
    bit [3:0]              m_hist [NREC];
    int                    m_cnt  [16];

    always #2 clk = ~clk;

    lhp_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid_i), .pred_addr_i(pred_addr_i), .pred_hint_i(pred_hint_i),
        .res_valid_i(res_valid_i), .res_addr_i(res_addr_i),
        .res_taken_i(res_taken_i), .res_hint_i(res_hint_i),
        .pred_valid_o(pred_valid_o), .pred_hit_o(pred_hit_o), .pred_taken_o(pred_taken_o)
    );

    function automatic bit m_hit(input logic [ADDR_W-1:0] a);
        return m_val[a[IDX_W-1:0]] && m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
    endfunction

    function automatic bit m_taken(input logic [ADDR_W-1:0] a);
        return m_hit(a) && m_cnt[m_hist[a[IDX_W-1:0]]] >= 2;
    endfunction

    task automatic m_resolve(input logic [ADDR_W-1:0] a, input bit t);
        int i = int'(a[IDX_W-1:0]);
        if (m_hit(a)) begin
            int h = int'(m_hist[i]);
            if (t && m_cnt[h] < 3) m_cnt[h]++;
            if (!t && m_cnt[h] > 0) m_cnt[h]--;
            m_hist[i] = {m_hist[i][2:0], t};
        end else begin
            m_val[i]  = 1'b1;
            m_tag[i]  = a[ADDR_W-1:IDX_W];
            m_hist[i] = 4'd0;
        end
    endtask

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, predict from the model, update the model, sample after the edge.
    task automatic step(input string req, input bit pv, input logic [ADDR_W-1:0] pa, input bit ph,
                        input bit rv, input logic [ADDR_W-1:0] ra, input bit rt, input bit rh);
        bit eh, et;
        @(negedge clk);
        pred_valid_i = pv; pred_addr_i = pa; pred_hint_i = ph;
        res_valid_i = rv; res_addr_i = ra; res_taken_i = rt; res_hint_i = rh;
        eh = pv && !ph && m_hit(pa);
        et = pv && !ph && m_taken(pa);
        if (rv && !rh) m_resolve(ra, rt);
        @(posedge clk); #1;
        check(req, "valid", pred_valid_o, pv);
        if (pv) begin
            check(req, "hit", pred_hit_o, eh);
            check(req, "taken", pred_taken_o, et);
        end
    endtask

    task automatic look(input string req, input logic [ADDR_W-1:0] a, input bit h);
        step(req, 1'b1, a, h, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic res(input string req, input logic [ADDR_W-1:0] a, input bit t, input bit h);
        step(req, 1'b0, '0, 1'b0, 1'b1, a, t, h);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] A = 32'h0000_1005;
        logic [ADDR_W-1:0] B = 32'h0000_2012;
        logic [ADDR_W-1:0] C = 32'h0000_3021;
        logic [ADDR_W-1:0] D = A + 32'd64;
        logic [ADDR_W-1:0] E = 32'h0000_4030;
        logic [ADDR_W-1:0] pool [8];
        void'($urandom(32'd1234));
        for (int i = 0; i < NREC; i++) begin m_val[i] = 0; m_tag[i] = '0; m_hist[i] = '0; end
        for (int i = 0; i < 16; i++) m_cnt[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0;

        look("R1", A, 0);
        step("R2", 0, '0, 0, 0, '0, 0, 0);
        res("R4", A, 1, 0);
        look("R4", A, 0);
        res("R6", A, 1, 0);
        res("R6", A, 0, 0);
        look("R6", A, 0);
        for (int k = 0; k < 8; k++) res("R7", B, 1, 0);
        look("R7", B, 0);
        for (int k = 0; k < 6; k++) res("R7", B, 0, 0);
        look("R7", B, 0);
        res("R8", C, 1, 0);
        look("R8", C, 0);
        look("R3", D, 0);
        res("R9", D, 0, 0);
        look("R9", A, 0);
        look("R9", D, 0);
        step("R10", 1, D, 0, 1, D, 1, 0);
        look("R10", D, 0);
        step("R10", 1, E, 0, 1, E, 1, 0);
        look("R10", E, 0);
        res("R5", 32'h0000_5007, 1, 1);
        look("R5", 32'h0000_5007, 0);
        look("R5", C, 1);
        res("R5", C, 1, 1);
        look("R5", C, 0);

        pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = D;
        pool[4] = E; pool[5] = A + 32'd128; pool[6] = 32'h0000_6005; pool[7] = B + 32'd64;
        for (int k = 0; k < 4000; k++) begin
            bit pv = ($urandom % 4) != 0;
            bit rv = ($urandom % 3) != 0;
            logic [ADDR_W-1:0] pa = pool[$urandom % 8];
            logic [ADDR_W-1:0] ra = pool[$urandom % 8];
            bit ph = ($urandom % 10) == 0;
            bit rh = ($urandom % 10) == 0;
            bit rt = ($urandom % 4) != 0;
            string lbl = ph ? "R5" : (!m_hit(pa) ? "R3" : "R7");
            step(lbl, pv, pa, ph, rv, ra, rt, rh);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule